// File: doc/BRIEF.md
# Audio Sample FIFO Status and Interrupt Unit

This block holds two sample queues for a serial audio port. The transmit queue is loaded by register writes and drained by the serial framer. The receive queue is filled by the framer and emptied by register reads. Both sides report their state through register fields. The transmit side reports how many slots are still free, and the receive side reports how many words are waiting.

Three interrupt sources are kept as sticky status bits that software clears by writing ones:

- transmit free space at or above a programmable trigger level;
- a framer pop from an empty transmit queue (underrun);
- receive data present.

An enable register gates these sources onto one interrupt line. The same register drives two request outputs toward a DMA engine. Two sample counters, one per direction, can be zeroed by a register write. The register port is a plain word-addressed read/write interface with a combinational read path. Bus protocol adaptation sits outside the block.

Top module: `audio_fifo_irq`

## Requirements
- R1: After reset:
  - both queues are empty;
  - the interrupt line and both request outputs are low;
  - the interrupt status register (address 2) reads 0x10 from the second clock after reset onward, because the empty transmit queue meets the default level.
- R2: The status register (address 1) carries the transmit free-slot count in bits 23:16 and the receive word count in bits 5:0. All other bits read zero.
- R3: A write to address 4 pushes the write data into the transmit queue, and the write is ignored when the queue holds 64 words. A pulse on tx_pop removes the oldest word. tx_data always shows the oldest word, so words leave in push order.
- R4: rx_push stores rx_data, and the push is ignored when the receive queue holds 32 words. A read of address 5 with reg_rd high returns the oldest word in the same cycle and removes it.
- R5: A pop from an empty queue leaves the counts unchanged. It returns the last word popped from that queue: tx_data for transmit, the address 5 read data for receive.
- R6: In the control register (address 0):
  - bits 18:12 hold the transmit trigger level, which resets to 0x40 and reads back;
  - writing 1 to bit 25 empties the transmit queue;
  - writing 1 to bit 24 empties the receive queue;
  - both flush bits clear themselves and read 0.
- R7: Interrupt status bit 4 becomes set one clock after a cycle in which the transmit free count is greater than or equal to the trigger level.
- R8: Interrupt status bit 6 becomes set one clock after tx_pop is asserted while the transmit queue is empty. The bit stays set until it is cleared.
- R9: Interrupt status bit 0 becomes set one clock after a cycle in which the receive queue is not empty.
- R10: Writing address 2 clears each status bit written with 1, unless that bit's condition holds in the same cycle. Bits written with 0 are not affected.
- R11: The enable register (address 3) stores bits 7, 6, 4, 3 and 0, and all other bits read zero. irq is high exactly when some status bit among 6, 4 and 0 is set and its enable bit of the same position is set.
- R12: The request outputs are combinational:
  - tx_dreq is high when enable bit 7 is set and the transmit free count is at or above the level;
  - rx_dreq is high when enable bit 3 is set and the receive queue is not empty.
- R13: Address 6 counts accepted transmit pops and address 7 counts accepted receive pushes. A write to either address zeroes that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Read strobe; pops the receive queue when the address is 5 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_pop | input | 1 | Framer takes one transmit word |
| tx_data | output | DATA_W | Oldest transmit word, or the last word popped when the queue is empty |
| rx_push | input | 1 | Framer delivers one receive word |
| rx_data | input | DATA_W | Receive word |
| irq | output | 1 | Interrupt request |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |

## Verification
The bench goes after each boundary case with a specific mistake in mind:

- **Full-queue pushes.** One push past capacity on each side; a design that accepts it would wrap its free count or overwrite the oldest word.
- **Trigger comparison.** Every fill level from empty to full is swept against trigger levels 0, 1, 31, 63, 64 and 127. An off-by-one comparison, or a level field taken from the wrong bits, shows up as a status bit that changes at the wrong fill.
- **Empty pops.** Both sides are popped while empty; a design that moves its pointer or counter on such a pop returns stale data, miscounts, or misses the underrun.
- **Write-one-to-clear.** Clears are checked both while the condition still holds and after it has gone; a design that clears all bits on any write, or lets the clear override a live condition, fails here.

// File: rtl/afu_pkg.sv
// Shared register addresses and field positions for the audio FIFO unit.
// Assumes a word-addressed register port with three address bits.
package afu_pkg;
    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_STAT  = 3'd1,
        A_ISTAT = 3'd2,
        A_IEN   = 3'd3,
        A_TXD   = 3'd4,
        A_RXD   = 3'd5,
        A_TXCNT = 3'd6,
        A_RXCNT = 3'd7
    } reg_addr_e;

    localparam int BIT_TXFLUSH = 25;
    localparam int BIT_RXFLUSH = 24;
    localparam int LVL_LSB     = 12;
    localparam int LVL_W       = 7;
    localparam int FREE_LSB    = 16;
    localparam int FREE_W      = 8;
    localparam int AVAIL_W     = 6;
    localparam int BIT_UR      = 6;
    localparam int BIT_TXE     = 4;
    localparam int BIT_RXA     = 0;
    localparam int BIT_TXDRQ   = 7;
    localparam int BIT_RXDRQ   = 3;
endpackage

// File: rtl/afu_fifo.sv
// Circular sample queue with a fill count, a flush input and hold-last output.
// Assumes DEPTH is a power of two. A push to a full queue and a pop from an
// empty queue are ignored. A flush wins over a push or pop in the same cycle.
// head shows the oldest word, or the last popped word while the queue is empty.
module afu_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  last_q;
    logic          is_empty, is_full, do_push, do_pop;

    assign is_empty = (cnt_q == '0);
    assign is_full  = (cnt_q == CW'(DEPTH));
    assign do_push  = push && !is_full && !flush;
    assign do_pop   = pop && !is_empty && !flush;

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data;
    end

    // Pointer and fill-count update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    // Remember the most recently popped word for empty-queue reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_q <= '0;
        else if (do_pop) last_q <= mem[rd_q];
    end

    assign head  = is_empty ? last_q : mem[rd_q];
    assign count = cnt_q;

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    p_full_push_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_full && !pop && !flush) |=> (cnt_q == CW'(DEPTH)));
    p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
    p_empty_pop_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && is_empty && !push) |=> ($stable(head) && count == '0));
endmodule

// File: rtl/afu_irq.sv
// Sticky interrupt status, enable register, interrupt line and DMA requests.
// Assumes FREE_W >= LVL_W. A status source that holds in the same cycle
// as a write-one-to-clear keeps its bit set.
module afu_irq #(
    parameter int FREE_W  = 8,
    parameter int AVAIL_W = 6,
    parameter int LVL_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FREE_W-1:0]  tx_free,
    input  logic [AVAIL_W-1:0] rx_avail,
    input  logic [LVL_W-1:0]   level,
    input  logic               underrun,
    input  logic               clr_wr,
    input  logic [2:0]         clr_mask,
    input  logic               en_wr,
    input  logic [7:0]         en_wdata,
    output logic [7:0]         stat_rd,
    output logic [7:0]         en_rd,
    output logic               irq,
    output logic               tx_dreq,
    output logic               rx_dreq
);
    localparam logic [7:0] EN_KEEP = 8'hD9;

    logic [2:0] stat_q;   // [2] underrun, [1] tx free at level, [0] rx data present
    logic [7:0] en_q;
    logic       txe_cond, rxa_cond;
    logic [2:0] set_v, clr_v;

    assign txe_cond = (tx_free >= FREE_W'(level));
    assign rxa_cond = (rx_avail != '0);
    assign set_v    = {underrun, txe_cond, rxa_cond};
    assign clr_v    = clr_wr ? clr_mask : 3'b000;

    // Status bits: set by their sources, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_v) | set_v;
    end

    // Enable register, keeping only the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata & EN_KEEP;
    end

    assign stat_rd = {1'b0, stat_q[2], 1'b0, stat_q[1], 3'b000, stat_q[0]};
    assign en_rd   = en_q;
    assign irq     = |(stat_rd & en_q);
    assign tx_dreq = en_q[7] & txe_cond;
    assign rx_dreq = en_q[3] & rxa_cond;

    p_ur_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[2] && !(clr_wr && clr_mask[2])) |=> stat_q[2]);
    p_w1c_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[2] && !underrun) |=> !stat_q[2]);
    p_txe_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        txe_cond |=> stat_q[1]);
    p_rxa_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rxa_cond |=> stat_q[0]);
    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == 3'b000) |-> !irq);
endmodule

// File: rtl/audio_fifo_irq.sv
// Top of the audio FIFO status and interrupt unit. Register writes load the
// transmit queue and the framer drains it. The framer fills the receive
// queue and register reads drain it.
// Assumes DATA_W <= 32, TX_DEPTH <= 255 and RX_DEPTH <= 63, both depths
// powers of two, so the counts fit their status fields.
module audio_fifo_irq
    import afu_pkg::*;
#(
    parameter int           DATA_W    = 32,
    parameter int           TX_DEPTH  = 64,
    parameter int           RX_DEPTH  = 32,
    parameter int           CNT_W     = 32,
    parameter logic [6:0]   LVL_RESET = 7'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    output logic              irq,
    output logic              tx_dreq,
    output logic              rx_dreq
);
    localparam int TX_CW = $clog2(TX_DEPTH + 1);
    localparam int RX_CW = $clog2(RX_DEPTH + 1);

    logic [LVL_W-1:0]   lvl_q;
    logic [CNT_W-1:0]   tx_scnt_q, rx_scnt_q;
    logic [TX_CW-1:0]   tx_cnt;
    logic [RX_CW-1:0]   rx_cnt;
    logic [DATA_W-1:0]  rx_head;
    logic [FREE_W-1:0]  tx_free;
    logic [AVAIL_W-1:0] rx_avail;
    logic [7:0]         stat_rd, en_rd;
    logic               wr_ctrl, tx_flush, rx_flush, tx_push, rx_pop;
    logic               tx_take, rx_take, underrun;

    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign tx_flush = wr_ctrl && reg_wdata[BIT_TXFLUSH];
    assign rx_flush = wr_ctrl && reg_wdata[BIT_RXFLUSH];
    assign tx_push  = reg_wr && (reg_addr == A_TXD);
    assign rx_pop   = reg_rd && (reg_addr == A_RXD);
    assign tx_take  = tx_pop && (tx_cnt != '0) && !tx_flush;
    assign rx_take  = rx_push && (rx_cnt != RX_CW'(RX_DEPTH)) && !rx_flush;
    assign underrun = tx_pop && (tx_cnt == '0);
    assign tx_free  = FREE_W'(TX_DEPTH) - FREE_W'(tx_cnt);
    assign rx_avail = AVAIL_W'(rx_cnt);

    afu_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push),
        .push_data(reg_wdata[DATA_W-1:0]), .pop(tx_pop),
        .head(tx_data), .count(tx_cnt)
    );

    afu_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push),
        .push_data(rx_data), .pop(rx_pop),
        .head(rx_head), .count(rx_cnt)
    );

    afu_irq #(.FREE_W(FREE_W), .AVAIL_W(AVAIL_W), .LVL_W(LVL_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .tx_free(tx_free), .rx_avail(rx_avail),
        .level(lvl_q), .underrun(underrun),
        .clr_wr(reg_wr && (reg_addr == A_ISTAT)),
        .clr_mask({reg_wdata[BIT_UR], reg_wdata[BIT_TXE], reg_wdata[BIT_RXA]}),
        .en_wr(reg_wr && (reg_addr == A_IEN)), .en_wdata(reg_wdata[7:0]),
        .stat_rd(stat_rd), .en_rd(en_rd), .irq(irq),
        .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
    );

    // Transmit trigger level register.
    always_ff @(posedge clk) begin
        if (!rst_n)       lvl_q <= LVL_RESET;
        else if (wr_ctrl) lvl_q <= reg_wdata[LVL_LSB +: LVL_W];
    end

    // Transmit sample counter: a clearing write wins over a pop.
    always_ff @(posedge clk) begin
        if (!rst_n || (reg_wr && reg_addr == A_TXCNT)) tx_scnt_q <= '0;
        else if (tx_take)                              tx_scnt_q <= tx_scnt_q + 1'b1;
    end

    // Receive sample counter: a clearing write wins over a push.
    always_ff @(posedge clk) begin
        if (!rst_n || (reg_wr && reg_addr == A_RXCNT)) rx_scnt_q <= '0;
        else if (rx_take)                              rx_scnt_q <= rx_scnt_q + 1'b1;
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = 32'(lvl_q) << LVL_LSB;
            A_STAT:  reg_rdata = (32'(tx_free) << FREE_LSB) | 32'(rx_avail);
            A_ISTAT: reg_rdata = 32'(stat_rd);
            A_IEN:   reg_rdata = 32'(en_rd);
            A_RXD:   reg_rdata = 32'(rx_head);
            A_TXCNT: reg_rdata = 32'(tx_scnt_q);
            A_RXCNT: reg_rdata = 32'(rx_scnt_q);
            default: reg_rdata = '0;
        endcase
    end

    p_txcnt_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TXCNT) |=> (tx_scnt_q == '0));
    p_rxcnt_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_RXCNT) |=> (rx_scnt_q == '0));
    p_underrun_no_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !(reg_wr && reg_addr == A_TXCNT)) |=> $stable(tx_scnt_q));
endmodule

// File: tb/test_audio_fifo_irq.sv
// Self-checking bench: sweeps queue fills, trigger levels and the clear rules.
module test_audio_fifo_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_pop = 1'b0;
    logic [31:0] tx_data;
    logic        rx_push = 1'b0;
    logic [31:0] rx_data = '0;
    logic        irq, tx_dreq, rx_dreq;

    int n_chk = 0;
    int n_bad = 0;

    audio_fifo_irq i_audio_fifo_irq (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_data(tx_data), .rx_push(rx_push),
        .rx_data(rx_data), .irq(irq), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rpop(output logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'd5; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic framer_pop();
        @(negedge clk);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic framer_push(input logic [31:0] d);
        @(negedge clk);
        rx_data = d; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    // Watchdog: an expired run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int lvls[6] = '{0, 1, 31, 63, 64, 127};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: outputs idle right after reset.
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 dreq", {30'b0, tx_dreq, rx_dreq}, 32'd0);
        rreg(3'd1, v); check("R1/R2 status", v, 32'd64 << 16);
        rreg(3'd0, v); check("R6 default level", v, 32'h40 << 12);
        tick();
        rreg(3'd2, v); check("R1 istat", v, 32'h10);

        // R3/R2: fill the transmit queue one word past capacity.
        for (int i = 0; i <= 64; i++) begin
            wreg(3'd4, 32'hA500_0000 + i);
            rreg(3'd1, v);
            check("R3 tx free", v, 32'((i < 64) ? 63 - i : 0) << 16);
        end

        // R3: drain in order.
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            check("R3 tx order", tx_data, 32'hA500_0000 + i);
            framer_pop();
        end
        rreg(3'd6, v); check("R13 tx count", v, 32'd64);

        // R5/R8: pop from empty transmit queue.
        framer_pop();
        tick();
        check("R5 tx hold", tx_data, 32'hA500_003F);
        rreg(3'd6, v); check("R5 tx count held", v, 32'd64);
        rreg(3'd2, v); check("R8 underrun set", v & 32'h40, 32'h40);
        wreg(3'd2, 32'h0); tick();
        rreg(3'd2, v); check("R10 write zero keeps", v, 32'h50);
        wreg(3'd2, 32'h40); tick();
        rreg(3'd2, v); check("R10 clear underrun", v, 32'h10);
        wreg(3'd2, 32'h10); tick();
        rreg(3'd2, v); check("R10 live cond keeps txe", v, 32'h10);
        wreg(3'd6, 32'h0);
        rreg(3'd6, v); check("R13 tx count clear", v, 32'd0);

        // R7/R12: trigger level swept against every fill.
        wreg(3'd3, 32'h80);
        foreach (lvls[k]) begin
            wreg(3'd0, (32'(lvls[k]) << 12) | (32'd1 << 25));
            rreg(3'd0, v); check("R6 level/flush self-clear", v, 32'(lvls[k]) << 12);
            for (int f = 0; f <= 64; f++) begin
                if (f > 0) wreg(3'd4, 32'(f));
                wreg(3'd2, 32'h10); tick();
                rreg(3'd2, v);
                check("R7 txe vs level", (v >> 4) & 32'd1, ((64 - f) >= lvls[k]) ? 32'd1 : 32'd0);
                check("R12 tx_dreq", {31'b0, tx_dreq}, ((64 - f) >= lvls[k]) ? 32'd1 : 32'd0);
            end
        end
        wreg(3'd0, (32'h40 << 12) | (32'd1 << 25));
        rreg(3'd1, v); check("R6 tx flush", v, 32'd64 << 16);

        // R4/R2/R9: fill the receive queue one past capacity.
        wreg(3'd3, 32'h08);
        check("R12 rx_dreq idle", {31'b0, rx_dreq}, 32'd0);
        for (int i = 0; i <= 32; i++) begin
            framer_push(32'h5A00_0000 + i);
            rreg(3'd1, v);
            check("R4 rx avail", v & 32'h3F, 32'((i < 32) ? i + 1 : 32));
        end
        rreg(3'd7, v); check("R13 rx count", v, 32'd32);
        rreg(3'd2, v); check("R9 rxa set", v & 32'h1, 32'h1);
        check("R12 rx_dreq", {31'b0, rx_dreq}, 32'd1);

        // R11: enable gating and readback.
        check("R11 irq gated off", {31'b0, irq}, 32'd0);
        wreg(3'd3, 32'h01); tick();
        check("R11 irq rxa", {31'b0, irq}, 32'd1);
        wreg(3'd3, 32'hFFFF_FFFF);
        rreg(3'd3, v); check("R11 enable readback", v, 32'hD9);
        wreg(3'd3, 32'h0); tick();
        check("R11 irq off", {31'b0, irq}, 32'd0);

        // R4: read out in order.
        for (int i = 0; i < 32; i++) begin
            rpop(v);
            check("R4 rx order", v, 32'h5A00_0000 + i);
        end
        rpop(v); check("R5 rx hold", v, 32'h5A00_001F);
        rreg(3'd1, v); check("R5 rx avail held", v & 32'h3F, 32'd0);
        wreg(3'd2, 32'h01); tick();
        rreg(3'd2, v); check("R9/R10 rxa cleared", v & 32'h1, 32'd0);
        wreg(3'd7, 32'h0);
        rreg(3'd7, v); check("R13 rx count clear", v, 32'd0);

        // R6: receive flush.
        for (int i = 0; i < 5; i++) framer_push(32'(i));
        rreg(3'd1, v); check("R6 rx before flush", v & 32'h3F, 32'd5);
        wreg(3'd0, (32'h40 << 12) | (32'd1 << 24));
        rreg(3'd1, v); check("R6 rx flush", v, 32'd64 << 16);

        // R11/R8: underrun drives irq when enabled.
        wreg(3'd2, 32'h51);
        wreg(3'd3, 32'h40); tick();
        check("R11 irq before underrun", {31'b0, irq}, 32'd0);
        framer_pop(); tick();
        check("R8 irq underrun", {31'b0, irq}, 32'd1);
        wreg(3'd2, 32'h40); tick();
        check("R10 irq after clear", {31'b0, irq}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule